// File: doc/BRIEF.md
# Multi-identity serial link frame command decoder

This block sits on the receive side of a five-wire serial audio link inside a codec that can serve as the primary device or as one of three secondaries sharing the same link. It takes the downstream serial stream one bit per bit-clock period, locates frame boundaries from the rising edge of the frame strobe, and collects the header word and the payload slots it needs. At the end of every frame it decides whether the command carried in the address and data slots is meant for this device. It then issues a read or write strobe with a 7-bit register address and a 16-bit write value.

Acceptance depends on the device identity, which comes from two active-low strapping pins. The primary trusts the address and data validity flags in the header. A secondary ignores those flags and instead compares the header's two-bit target field with its own identity. The identity also selects which two payload slots feed the left and right converter samples. The block also presents the fixed value of the read-only extended identification register, with the identity folded into its top two bits.

Top module: `aclink_rx_decoder`

## Requirements
- R1: The identity is the bitwise inverse of `ident_pin_n` (identity 0 is the primary, 1 to 3 are secondaries), and `ext_id_word` always equals 16'h0201 with the identity placed in bits 15:14.
- R2: A frame is 256 bits: a 16-bit header followed by twelve 20-bit slots numbered 1 to 12, each sent MSB first and sampled on the falling edge of `bit_clk`. A rising `sync` marks the first header bit. No command or sample is produced before the first rising `sync`.
- R3: For identity 0, a read strobe is produced when header bit 14 is 1, header bits 1:0 are 00 and slot 1 bit 19 is 1. If header bits 1:0 are nonzero, the primary produces no strobe.
- R4: For identity 0, a write strobe needs header bits 14 and 13 both set in the same frame, header bits 1:0 equal to 00, and slot 1 bit 19 equal to 0. An address flag without the data flag gives no write.
- R5: For a nonzero identity, a command is accepted exactly when header bits 1:0 equal the identity, whatever the values of header bits 14 and 13. A read or write is then selected by slot 1 bit 19. A mismatch gives no strobe.
- R6: The register address is slot 1 bits 18:12 and the write value is slot 2 bits 19:4. `cmd_addr` changes only together with an accepted read or write. `cmd_wdata` changes only together with a write strobe. Both hold their values otherwise.
- R7: Each strobe is high for exactly one `bit_clk` cycle. It rises at the falling edge that samples the last bit of the frame, and the read and write strobes are never high together.
- R8: The left/right source slots are 3/4 for identities 0 and 1, 7/8 for identity 2, and 6/9 for identity 3.
- R9: Each converter output takes bits 19:2 of its source slot at frame end, but only if the header bit for that slot (bit 15 minus the slot number) is 1. Otherwise it holds its value.
- R10: While `rst_n` is low, both strobes, `cmd_addr`, `cmd_wdata` and both converter outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Link bit clock; serial data is sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame strobe; its rising edge marks header bit 15 |
| ser_in | input | 1 | Downstream serial data, MSB first |
| ident_pin_n | input | 2 | Active-low identity strapping pins |
| cmd_rd_stb | output | 1 | One-cycle register read request |
| cmd_wr_stb | output | 1 | One-cycle register write request |
| cmd_addr | output | 7 | Register address of the last accepted command |
| cmd_wdata | output | 16 | Write value of the last accepted write |
| dac_left | output | 18 | Left converter sample |
| dac_right | output | 18 | Right converter sample |
| ext_id_word | output | 16 | Read-only extended identification value |

## Verification
Frames are sent under all four identities. For the primary, the bench tries header patterns with both flags set, with only the address flag, and with a nonzero target field; these separate proper flag decoding from ignoring the target field or from treating a lone address as a write. For the secondaries, the bench sends headers where the target field matches while both flags are clear, and headers where it mismatches while both flags are set; this shows that the flags are ignored and the identity match alone decides. Every payload slot holds a distinct value and several slot-valid flags are set at once. A wrong slot mapping, a missing valid gate or a shifted sample slice therefore shows up as a wrong converter value on the first frame where it matters.

// File: rtl/aclink_rx_pkg.sv
package aclink_rx_pkg;

    localparam int TAG_W      = 16;   // header slot length
    localparam int SLOT_W     = 20;   // payload slot length
    localparam int LAST_SLOT  = 12;   // number of payload slots
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 16;
    localparam int DAC_W      = 18;
    localparam int ID_W       = 2;
    localparam int SLOT_IDX_W = $clog2(LAST_SLOT + 1);

    localparam logic [TAG_W-1:0] EXT_ID_BASE = 16'h0201;

    typedef logic [ID_W-1:0]       codec_id_t;
    typedef logic [SLOT_IDX_W-1:0] slot_idx_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } cmd_t;

    // payload slot feeding the left converter for a given identity
    function automatic slot_idx_t left_slot_of(codec_id_t id);
        case (id)
            2'b10:   return slot_idx_t'(7);
            2'b11:   return slot_idx_t'(6);
            default: return slot_idx_t'(3);
        endcase
    endfunction

    // payload slot feeding the right converter for a given identity
    function automatic slot_idx_t right_slot_of(codec_id_t id);
        case (id)
            2'b10:   return slot_idx_t'(8);
            2'b11:   return slot_idx_t'(9);
            default: return slot_idx_t'(4);
        endcase
    endfunction

    // header validity flag of slot n sits at bit (TAG_W-1-n)
    function automatic logic slot_flag(logic [TAG_W-1:0] tag, slot_idx_t n);
        logic [TAG_W-1:0] t;
        t = tag << n;
        return t[TAG_W-1];
    endfunction

endpackage

// File: rtl/rx_frame_timer.sv
module rx_frame_timer #(
    parameter  int HEAD_LEN = 16,
    parameter  int SLOT_LEN = 20,
    parameter  int LAST     = 12,
    localparam int PW       = $clog2(SLOT_LEN),
    localparam int IW       = $clog2(LAST + 1)
) (
    input  logic          bit_clk,
    input  logic          rst_n,
    input  logic          sync,
    output logic [IW-1:0] slot_idx,
    output logic          slot_done,
    output logic          frame_done
);

    typedef struct packed {
        logic          sync_prev;
        logic          locked;
        logic [IW-1:0] slot;
        logic [PW-1:0] pos;
    } tstate_t;

    tstate_t       q, d;
    logic          rise;
    logic          live;
    logic [PW-1:0] pos_now;
    logic [PW-1:0] pos_end;

    always_comb begin
        rise       = sync & ~q.sync_prev;
        live       = q.locked | rise;
        slot_idx   = rise ? '0 : q.slot;
        pos_now    = rise ? '0 : q.pos;
        pos_end    = (slot_idx == '0) ? PW'(HEAD_LEN - 1) : PW'(SLOT_LEN - 1);
        slot_done  = (pos_now == pos_end);
        frame_done = slot_done & live & (slot_idx == IW'(LAST));

        d           = q;
        d.sync_prev = sync;
        d.locked    = live;
        if (slot_done) begin
            d.pos  = '0;
            d.slot = (slot_idx == IW'(LAST)) ? '0 : slot_idx + 1'b1;
        end else begin
            d.pos  = pos_now + 1'b1;
            d.slot = slot_idx;
        end
    end

    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/rx_slot_store.sv
module rx_slot_store #(
    parameter int HEAD_LEN = 16,
    parameter int SLOT_LEN = 20,
    parameter int IW       = 4,
    parameter int CMD_W    = 8,
    parameter int DATA_W   = 16,
    parameter int DAC_W    = 18
) (
    input  logic                bit_clk,
    input  logic                rst_n,
    input  logic                ser_in,
    input  logic [IW-1:0]       slot_idx,
    input  logic                slot_done,
    input  logic [IW-1:0]       left_sel,
    input  logic [IW-1:0]       right_sel,
    output logic [HEAD_LEN-1:0] tag,
    output logic [CMD_W-1:0]    cmd_hi,
    output logic [DATA_W-1:0]   data_word,
    output logic [DAC_W-1:0]    left_word,
    output logic [DAC_W-1:0]    right_word
);

    typedef struct packed {
        logic [SLOT_LEN-2:0] sh;
        logic [HEAD_LEN-1:0] tag;
        logic [CMD_W-1:0]    cmd;
        logic [DATA_W-1:0]   data;
        logic [DAC_W-1:0]    left;
        logic [DAC_W-1:0]    right;
    } sstate_t;

    sstate_t             q, d;
    logic [SLOT_LEN-1:0] word;

    always_comb begin
        word = {q.sh, ser_in};
        d    = q;
        d.sh = word[SLOT_LEN-2:0];
        if (slot_done) begin
            if (slot_idx == IW'(0)) d.tag  = word[HEAD_LEN-1:0];
            if (slot_idx == IW'(1)) d.cmd  = word[SLOT_LEN-1 -: CMD_W];
            if (slot_idx == IW'(2)) d.data = word[SLOT_LEN-1 -: DATA_W];
            if (slot_idx == left_sel)  d.left  = word[SLOT_LEN-1 -: DAC_W];
            if (slot_idx == right_sel) d.right = word[SLOT_LEN-1 -: DAC_W];
        end
    end

    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tag        = q.tag;
    assign cmd_hi     = q.cmd;
    assign data_word  = q.data;
    assign left_word  = q.left;
    assign right_word = q.right;

endmodule

// File: rtl/rx_cmd_decode.sv
module rx_cmd_decode #(
    parameter int TAG_W  = 16,
    parameter int ID_W   = 2,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic [ID_W-1:0]   ident,
    input  logic [TAG_W-1:0]  tag,
    input  logic [ADDR_W:0]   cmd_hi,
    input  logic [DATA_W-1:0] data_word,
    output logic              acc_rd,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);

    logic            addr_ok;
    logic            data_ok;
    logic [ID_W-1:0] target;

    always_comb begin
        target = tag[ID_W-1:0];
        if (ident == '0) begin
            // primary: header flags qualify the command, target field must be clear
            addr_ok = tag[TAG_W-2] & (target == '0);
            data_ok = tag[TAG_W-3];
        end else begin
            // secondary: identity match qualifies both slots
            addr_ok = (target == ident);
            data_ok = addr_ok;
        end
        acc_rd = addr_ok &  cmd_hi[ADDR_W];
        acc_wr = addr_ok & ~cmd_hi[ADDR_W] & data_ok;
        addr   = cmd_hi[ADDR_W-1:0];
        wdata  = data_word;
    end

endmodule

// File: rtl/aclink_rx_decoder.sv
module aclink_rx_decoder
    import aclink_rx_pkg::*;
(
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              sync,
    input  logic              ser_in,
    input  logic [ID_W-1:0]   ident_pin_n,
    output logic              cmd_rd_stb,
    output logic              cmd_wr_stb,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    output logic [DAC_W-1:0]  dac_left,
    output logic [DAC_W-1:0]  dac_right,
    output logic [TAG_W-1:0]  ext_id_word
);

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DAC_W-1:0]  left;
        logic [DAC_W-1:0]  right;
    } ostate_t;

    codec_id_t         ident;
    slot_idx_t         slot_idx;
    slot_idx_t         left_sel;
    slot_idx_t         right_sel;
    logic              slot_done;
    logic              frame_done;
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W:0]   cmd_hi;
    logic [DATA_W-1:0] data_word;
    logic [DAC_W-1:0]  left_word;
    logic [DAC_W-1:0]  right_word;
    cmd_t              dec;
    ostate_t           q, d;

    assign ident     = ~ident_pin_n;
    assign left_sel  = left_slot_of(ident);
    assign right_sel = right_slot_of(ident);

    rx_frame_timer #(
        .HEAD_LEN (TAG_W),
        .SLOT_LEN (SLOT_W),
        .LAST     (LAST_SLOT)
    ) u_timer (
        .bit_clk    (bit_clk),
        .rst_n      (rst_n),
        .sync       (sync),
        .slot_idx   (slot_idx),
        .slot_done  (slot_done),
        .frame_done (frame_done)
    );

    rx_slot_store #(
        .HEAD_LEN (TAG_W),
        .SLOT_LEN (SLOT_W),
        .IW       (SLOT_IDX_W),
        .CMD_W    (ADDR_W + 1),
        .DATA_W   (DATA_W),
        .DAC_W    (DAC_W)
    ) u_store (
        .bit_clk    (bit_clk),
        .rst_n      (rst_n),
        .ser_in     (ser_in),
        .slot_idx   (slot_idx),
        .slot_done  (slot_done),
        .left_sel   (left_sel),
        .right_sel  (right_sel),
        .tag        (tag),
        .cmd_hi     (cmd_hi),
        .data_word  (data_word),
        .left_word  (left_word),
        .right_word (right_word)
    );

    rx_cmd_decode #(
        .TAG_W  (TAG_W),
        .ID_W   (ID_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .ident     (ident),
        .tag       (tag),
        .cmd_hi    (cmd_hi),
        .data_word (data_word),
        .acc_rd    (dec.rd),
        .acc_wr    (dec.wr),
        .addr      (dec.addr),
        .wdata     (dec.wdata)
    );

    always_comb begin
        d    = q;
        d.rd = 1'b0;
        d.wr = 1'b0;
        if (frame_done) begin
            d.rd = dec.rd;
            d.wr = dec.wr;
            if (dec.rd || dec.wr) d.addr  = dec.addr;
            if (dec.wr)           d.wdata = dec.wdata;
            if (slot_flag(tag, left_sel))  d.left  = left_word;
            if (slot_flag(tag, right_sel)) d.right = right_word;
        end
    end

    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_rd_stb  = q.rd;
    assign cmd_wr_stb  = q.wr;
    assign cmd_addr    = q.addr;
    assign cmd_wdata   = q.wdata;
    assign dac_left    = q.left;
    assign dac_right   = q.right;
    assign ext_id_word = {ident, EXT_ID_BASE[TAG_W-ID_W-1:0]};

endmodule

// File: rtl/aclink_rx_checker.sv
module aclink_rx_checker
    import aclink_rx_pkg::*;
(
    input logic              bit_clk,
    input logic              rst_n,
    input logic              cmd_rd_stb,
    input logic              cmd_wr_stb,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_wdata,
    input logic [DAC_W-1:0]  dac_left,
    input logic [DAC_W-1:0]  dac_right,
    input logic              frame_done,
    input logic [TAG_W-1:0]  tag,
    input logic [ID_W-1:0]   ident
);

    a_r7_strobes_exclusive: assert property (@(negedge bit_clk) disable iff (!rst_n)
        !(cmd_rd_stb && cmd_wr_stb));

    a_r7_single_cycle: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (cmd_rd_stb || cmd_wr_stb) |=> !(cmd_rd_stb || cmd_wr_stb));

    a_r7_strobe_after_frame_end: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (cmd_rd_stb || cmd_wr_stb) |-> $past(frame_done));

    a_r6_addr_moves_with_cmd: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (cmd_addr != $past(cmd_addr)) |-> (cmd_rd_stb || cmd_wr_stb));

    a_r6_wdata_moves_with_write: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (cmd_wdata != $past(cmd_wdata)) |-> cmd_wr_stb);

    a_r9_left_at_frame_end: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (dac_left != $past(dac_left)) |-> $past(frame_done));

    a_r9_right_at_frame_end: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (dac_right != $past(dac_right)) |-> $past(frame_done));

    a_r5_secondary_match: assert property (@(negedge bit_clk) disable iff (!rst_n)
        ((cmd_rd_stb || cmd_wr_stb) && ident != '0) |-> (tag[ID_W-1:0] == ident));

    a_r3_primary_addr_flag: assert property (@(negedge bit_clk) disable iff (!rst_n)
        ((cmd_rd_stb || cmd_wr_stb) && ident == '0) |-> (tag[TAG_W-2] && tag[ID_W-1:0] == '0));

    a_r4_primary_data_flag: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (cmd_wr_stb && ident == '0) |-> tag[TAG_W-3]);

endmodule

bind aclink_rx_decoder aclink_rx_checker u_chk (
    .bit_clk    (bit_clk),
    .rst_n      (rst_n),
    .cmd_rd_stb (cmd_rd_stb),
    .cmd_wr_stb (cmd_wr_stb),
    .cmd_addr   (cmd_addr),
    .cmd_wdata  (cmd_wdata),
    .dac_left   (dac_left),
    .dac_right  (dac_right),
    .frame_done (frame_done),
    .tag        (tag),
    .ident      (ident)
);

// File: tb/aclink_rx_decoder_test.sv
module aclink_rx_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync = 1'b0;
    logic        ser_in = 1'b0;
    logic [1:0]  ident_pin_n = 2'b11;
    logic        cmd_rd_stb, cmd_wr_stb;
    logic [6:0]  cmd_addr;
    logic [15:0] cmd_wdata;
    logic [17:0] dac_left, dac_right;
    logic [15:0] ext_id_word;

    always #10 clk = ~clk;   // 50 MHz

    aclink_rx_decoder uut (
        .bit_clk     (clk),
        .rst_n       (rst_n),
        .sync        (sync),
        .ser_in      (ser_in),
        .ident_pin_n (ident_pin_n),
        .cmd_rd_stb  (cmd_rd_stb),
        .cmd_wr_stb  (cmd_wr_stb),
        .cmd_addr    (cmd_addr),
        .cmd_wdata   (cmd_wdata),
        .dac_left    (dac_left),
        .dac_right   (dac_right),
        .ext_id_word (ext_id_word)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int bitno = 0;
    string ctx = "R10 reset";

    // reference model state
    int          cur_id = 0;
    logic        e_rd = 0, e_wr = 0;
    logic [6:0]  e_addr = 0;
    logic [15:0] e_wdata = 0;
    logic [17:0] e_dl = 0, e_dr = 0;

    logic [15:0] f_tag;
    logic [19:0] f_slot [1:12];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s: actual %h expected %h (bit %0d)", req, ctx, what, act, exp, bitno);
        end
    endtask

    task automatic compare_all();
        logic [15:0] e_ext;
        e_ext = 16'h0201 | 16'(cur_id << 14);
        chk("R3", "read strobe",  32'(cmd_rd_stb), 32'(e_rd));
        chk("R4", "write strobe", 32'(cmd_wr_stb), 32'(e_wr));
        chk("R6", "address",      32'(cmd_addr),   32'(e_addr));
        chk("R6", "write value",  32'(cmd_wdata),  32'(e_wdata));
        chk("R8", "left sample",  32'(dac_left),   32'(e_dl));
        chk("R9", "right sample", 32'(dac_right),  32'(e_dr));
        chk("R1", "ext id",       32'(ext_id_word), 32'(e_ext));
    endtask

    task automatic model_frame_end();
        bit acc_a, acc_d;
        int ls, rs;
        if (cur_id == 0) begin
            acc_a = f_tag[14] && (f_tag[1:0] == 2'b00);
            acc_d = f_tag[13];
        end else begin
            acc_a = (f_tag[1:0] == cur_id[1:0]);
            acc_d = acc_a;
        end
        e_rd = acc_a && f_slot[1][19];
        e_wr = acc_a && !f_slot[1][19] && acc_d;
        if (e_rd || e_wr) e_addr  = f_slot[1][18:12];
        if (e_wr)         e_wdata = f_slot[2][19:4];
        case (cur_id)
            2:       begin ls = 7; rs = 8; end
            3:       begin ls = 6; rs = 9; end
            default: begin ls = 3; rs = 4; end
        endcase
        if (f_tag[15 - ls]) e_dl = f_slot[ls][19:2];
        if (f_tag[15 - rs]) e_dr = f_slot[rs][19:2];
    endtask

    task automatic idle_bits(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            compare_all();
            sync = 1'b0;
            ser_in = 1'b1;
            e_rd = 0; e_wr = 0;
        end
    endtask

    task automatic send_frame(int new_id);
        for (int i = 0; i < 256; i++) begin
            logic b;
            int   s, p;
            @(posedge clk); #1;
            bitno = i;
            compare_all();
            if (i < 16) b = f_tag[15 - i];
            else begin
                s = (i - 16) / 20 + 1;
                p = 19 - (i - 16) % 20;
                b = f_slot[s][p];
            end
            sync   = (i < 16);
            ser_in = b;
            if (i == 8) begin
                ident_pin_n = ~new_id[1:0];
                cur_id = new_id;
            end
            e_rd = 0; e_wr = 0;
            if (i == 255) model_frame_end();
        end
    endtask

    task automatic fill(logic [19:0] base, logic rd, logic [6:0] addr, logic [15:0] data);
        for (int n = 1; n <= 12; n++) f_slot[n] = base ^ 20'(n * 32'h0E3C5);
        f_slot[1] = {rd, addr, 12'h5A3};
        f_slot[2] = {data, 4'h9};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired at bit %0d", bitno);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R10: reset values held while reset is low
        ident_pin_n = 2'b11; cur_id = 0;
        ctx = "R10 reset";
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            compare_all();
        end
        rst_n = 1'b1;

        // R2: no output before the first rising sync
        ctx = "R2 idle before sync";
        idle_bits(40);

        // R3: primary read with both sample slots valid
        ctx = "R3 primary read";
        fill(20'hABCDE, 1'b1, 7'h28, 16'h1111); f_tag = 16'hD800;
        send_frame(0);

        // R4: primary write, only left sample valid
        ctx = "R4 primary write";
        fill(20'h13579, 1'b0, 7'h02, 16'h8080); f_tag = 16'hF000;
        send_frame(0);

        // R4: address flag alone gives no write
        ctx = "R4 address without data";
        fill(20'h2468A, 1'b0, 7'h11, 16'hDEAD); f_tag = 16'hC000;
        send_frame(0);

        // R3: primary ignores a frame aimed at a secondary
        ctx = "R3 primary nonzero target";
        fill(20'h0F0F0, 1'b0, 7'h33, 16'hBEEF); f_tag = 16'hE001;
        send_frame(0);

        // R5: secondary 1 write with flags clear (R2 back-to-back framing)
        ctx = "R5 secondary 1 match";
        fill(20'h55AA5, 1'b0, 7'h44, 16'hCAFE); f_tag = 16'h9801;
        send_frame(1);

        // R5: secondary 1 mismatch with flags set
        ctx = "R5 secondary 1 mismatch";
        fill(20'h7E7E7, 1'b0, 7'h55, 16'h0F0F); f_tag = 16'hF802;
        send_frame(1);

        // R8: secondary 2 read, slots 3/4 also valid as distractors
        ctx = "R8 secondary 2 read";
        fill(20'h3C3C3, 1'b1, 7'h28, 16'h7777); f_tag = 16'h1982;
        send_frame(2);

        // R8: secondary 3 write, slots 6/9 selected
        ctx = "R8 secondary 3 write";
        fill(20'h9A9A9, 1'b0, 7'h7F, 16'h1234); f_tag = 16'h1343;
        send_frame(3);

        // R9: secondary 3 with only right slot valid
        ctx = "R9 right slot only";
        fill(20'hE1E1E, 1'b1, 7'h01, 16'h4321); f_tag = 16'h0043;
        send_frame(3);

        // R5: secondary 2 mismatch
        ctx = "R5 secondary 2 mismatch";
        fill(20'h4B4B4, 1'b0, 7'h66, 16'hABCD); f_tag = 16'h61C3;
        send_frame(2);

        // R7: empty frame shows the previous strobe drop after one cycle
        ctx = "R7 quiet frame";
        fill(20'h00000, 1'b0, 7'h00, 16'h0000); f_tag = 16'h0000;
        send_frame(0);

        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            compare_all();
            e_rd = 0; e_wr = 0;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule